// File: doc/BRIEF.md
# Transmit FIFO with Threshold Release

This block sits on the transmit path between a DMA engine that writes frame bytes and a MAC that reads them. Bytes arrive one per accepted beat with a marker on the final byte of each frame. The read side sees the same bytes, in the same order and with the same marker. The FIFO decides when the first byte of each frame is offered to the MAC.

In store-and-forward mode a frame is held back until its final byte has been stored. This mode is also forced whenever full checksum insertion is requested, because the checksum cannot be inserted into a frame that is already leaving. In threshold mode a frame is offered once enough bytes are stored. The start level is derived from a requested byte count: the request rounds up to the nearest of 32, 64, 128, 192 or 256 bytes, and any request above 192 uses 256. A frame shorter than the start level is offered once it is complete. After the first byte of a frame has been read, its later bytes are offered whenever they are stored.

A one-cycle flush empties the storage. A flush request raises a busy flag for exactly the following cycle, and the flag then clears by itself. In threshold mode the reader can drain the FIFO in the middle of a frame. When that happens, the block raises a sticky underflow flag, flushes itself, and discards the remaining bytes of the broken frame as they are written.

Top module: `tx_thresh_fifo`

## Requirements
- R1: After reset, rd_valid_o, flush_busy_o and underflow_o are 0 and wr_ready_o is 1.
- R2: Bytes are read out in the order they were accepted, and each keeps its last-byte marker.
- R3: With cfg_sf_i=1, no byte of a frame is offered on the read side until the last byte of that frame has been stored.
- R4: With cfg_csum_full_i=1, the block behaves as in R3 whatever the value of cfg_sf_i.
- R5: In threshold mode (cfg_sf_i=0, cfg_csum_full_i=0), the first byte of a frame is offered once the stored byte count reaches the start level. A request of at most 32 gives a start level of 32. A request of 33 to 64 gives 64. A request of 65 to 128 gives 128. A request of 129 to 192 gives 192. Any larger request gives 256.
- R6: In threshold mode, a frame shorter than the start level is offered once its last byte has been stored.
- R7: A flush_i pulse makes flush_busy_o 1 for exactly the next cycle. After that cycle, the FIFO is empty.
- R8: While flush_busy_o is 1, wr_ready_o and rd_valid_o are 0, and a write offered in that cycle is not stored.
- R9: An underflow occurs when rd_ready_i is 1 while a frame is partly read and no byte is stored. It sets underflow_o in the next cycle and starts a flush in that same cycle. underflow_o then stays 1 until flush_i is sampled.
- R10: After an underflow, the writes that remain in the broken frame, up to and including its last byte, are accepted and discarded. The next frame is stored and read normally.
- R11: Once the first byte of a frame has been read, its later bytes are offered whenever stored, even when the count drops below the start level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write byte offered |
| wr_data_i | input | DATA_W | Write byte |
| wr_last_i | input | 1 | Write byte ends its frame |
| wr_ready_o | output | 1 | Write byte accepted this cycle |
| rd_valid_o | output | 1 | Read byte offered |
| rd_data_o | output | DATA_W | Read byte |
| rd_last_o | output | 1 | Read byte ends its frame |
| rd_ready_i | input | 1 | Reader takes the byte, or needs one |
| cfg_sf_i | input | 1 | Store-and-forward mode select |
| cfg_csum_full_i | input | 1 | Full checksum insertion active; forces store-and-forward |
| cfg_thr_req_i | input | REQ_W | Requested start level in bytes for threshold mode |
| flush_i | input | 1 | Flush request |
| flush_busy_o | output | 1 | Flush in progress; clears by itself |
| underflow_o | output | 1 | Sticky underflow flag |

## Verification
A wrong byte count or wrong start-level mapping shows up on rd_valid_o in the same cycle as the write that crosses the level. The bench therefore compares rd_valid_o after every single write, for requests on each side of every step of the mapping. A wrong frame counter shows up as a frame released early in store-and-forward mode, or never released when it is short. A bad pointer or a leftover from a flush shows up as a wrong byte or marker at the first read that follows. A missed discard after an underflow shows up as stray bytes ahead of the next frame.

// File: rtl/tx_fifo_pkg.sv
package tx_fifo_pkg;

  localparam int unsigned NUM_THR = 5;
  localparam int unsigned THR_W   = 9;

  // start level in bytes for each ascending code
  function automatic logic [THR_W-1:0] thr_bytes(input int unsigned code);
    case (code)
      0:       return THR_W'(32);
      1:       return THR_W'(64);
      2:       return THR_W'(128);
      3:       return THR_W'(192);
      default: return THR_W'(256);
    endcase
  endfunction

endpackage

// File: rtl/tx_fifo_thr_map.sv
module tx_fifo_thr_map
  import tx_fifo_pkg::*;
#(
  parameter int unsigned REQ_W = 9
) (
  input  logic [REQ_W-1:0] req_i,
  input  logic             sf_mode_i,
  input  logic             csum_full_i,
  output logic [THR_W-1:0] start_lvl_o,
  output logic             sf_eff_o
);

  logic [NUM_THR-1:0] hit;

  for (genvar k = 0; k < NUM_THR; k++) begin : g_cmp
    assign hit[k] = (32'(req_i) <= 32'(thr_bytes(k)));
  end

  // smallest setting at or above the request, else the top one
  always_comb begin
    int unsigned code;
    code = NUM_THR - 1;
    for (int k = NUM_THR - 1; k >= 0; k--) begin
      if (hit[k]) code = k;
    end
    start_lvl_o = thr_bytes(code);
  end

  assign sf_eff_o = sf_mode_i | csum_full_i;

endmodule

// File: rtl/tx_fifo_store.sv
module tx_fifo_store #(
  parameter  int unsigned DATA_W = 8,
  parameter  int unsigned DEPTH  = 512,
  localparam int unsigned AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              push_last_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_data_o,
  output logic              head_last_o,
  output logic [CW-1:0]     level_o,
  output logic [CW-1:0]     frames_o,
  output logic              empty_o,
  output logic              full_o
);

  logic [DATA_W:0] mem_q [DEPTH];
  logic [AW-1:0]   wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]   cnt_q, frm_q;
  logic            frm_in, frm_out;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign frm_in  = push_i & push_last_i;
  assign frm_out = pop_i & head_last_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      frm_q    <= '0;
    end else if (clear_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      frm_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
      case ({frm_in, frm_out})
        2'b10:   frm_q <= frm_q + CW'(1);
        2'b01:   frm_q <= frm_q - CW'(1);
        default: frm_q <= frm_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !clear_i) mem_q[wr_ptr_q] <= {push_last_i, push_data_i};
  end

  assign {head_last_o, head_data_o} = mem_q[rd_ptr_q];
  assign level_o  = cnt_q;
  assign frames_o = frm_q;
  assign empty_o  = (cnt_q == '0);
  assign full_o   = (cnt_q == CW'(DEPTH));

endmodule

// File: rtl/tx_fifo_rd_ctrl.sv
module tx_fifo_rd_ctrl #(
  parameter int unsigned CW    = 10,
  parameter int unsigned THR_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             block_i,
  input  logic             empty_i,
  input  logic [CW-1:0]    level_i,
  input  logic [CW-1:0]    frames_i,
  input  logic [THR_W-1:0] start_lvl_i,
  input  logic             sf_eff_i,
  input  logic             head_last_i,
  input  logic             rd_ready_i,
  output logic             rd_valid_o,
  output logic             pop_o,
  output logic             uf_evt_o,
  output logic             in_frame_o
);

  logic in_frame_q;
  logic start_ok;

  // release of a new frame: complete frame stored, or level reached in threshold mode
  assign start_ok = (frames_i != '0) ||
                    (!sf_eff_i && (32'(level_i) >= 32'(start_lvl_i)));

  assign rd_valid_o = !block_i && !empty_i && (in_frame_q || start_ok);
  assign pop_o      = rd_valid_o & rd_ready_i;
  assign uf_evt_o   = !block_i && in_frame_q && rd_ready_i && empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      in_frame_q <= 1'b0;
    else if (block_i) in_frame_q <= 1'b0;
    else if (pop_o)   in_frame_q <= !head_last_i;
  end

  assign in_frame_o = in_frame_q;

endmodule

// File: rtl/tx_thresh_fifo.sv
module tx_thresh_fifo
  import tx_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 512,
  parameter int unsigned REQ_W  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_last_i,
  output logic              wr_ready_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_last_o,
  input  logic              rd_ready_i,
  input  logic              cfg_sf_i,
  input  logic              cfg_csum_full_i,
  input  logic [REQ_W-1:0]  cfg_thr_req_i,
  input  logic              flush_i,
  output logic              flush_busy_o,
  output logic              underflow_o
);

  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic             flush_q, uf_q, drop_q;
  logic             wr_acc, push, pop, uf_evt;
  logic             empty, full, head_last, sf_eff, in_frame;
  logic [DATA_W-1:0] head_data;
  logic [CW-1:0]    level, frames;
  logic [THR_W-1:0] start_lvl;

  tx_fifo_thr_map #(.REQ_W(REQ_W)) u_map (
    .req_i       (cfg_thr_req_i),
    .sf_mode_i   (cfg_sf_i),
    .csum_full_i (cfg_csum_full_i),
    .start_lvl_o (start_lvl),
    .sf_eff_o    (sf_eff)
  );

  // writes in drop state are taken and discarded
  assign wr_ready_o = !flush_q && (drop_q || !full);
  assign wr_acc     = wr_valid_i && wr_ready_o;
  assign push       = wr_acc && !drop_q;

  tx_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (flush_q),
    .push_i      (push),
    .push_data_i (wr_data_i),
    .push_last_i (wr_last_i),
    .pop_i       (pop),
    .head_data_o (head_data),
    .head_last_o (head_last),
    .level_o     (level),
    .frames_o    (frames),
    .empty_o     (empty),
    .full_o      (full)
  );

  tx_fifo_rd_ctrl #(.CW(CW), .THR_W(THR_W)) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .block_i     (flush_q),
    .empty_i     (empty),
    .level_i     (level),
    .frames_i    (frames),
    .start_lvl_i (start_lvl),
    .sf_eff_i    (sf_eff),
    .head_last_i (head_last),
    .rd_ready_i  (rd_ready_i),
    .rd_valid_o  (rd_valid_o),
    .pop_o       (pop),
    .uf_evt_o    (uf_evt),
    .in_frame_o  (in_frame)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_q <= 1'b0;
      uf_q    <= 1'b0;
      drop_q  <= 1'b0;
    end else begin
      flush_q <= flush_i | uf_evt;
      if (uf_evt)       uf_q <= 1'b1;
      else if (flush_i) uf_q <= 1'b0;
      // writer is mid-frame on underflow; skip until its last byte
      if (uf_evt && !(wr_acc && wr_last_i)) drop_q <= 1'b1;
      else if (drop_q && wr_acc && wr_last_i) drop_q <= 1'b0;
    end
  end

  assign rd_data_o    = head_data;
  assign rd_last_o    = head_last;
  assign flush_busy_o = flush_q;
  assign underflow_o  = uf_q;

endmodule

// File: rtl/tx_fifo_chk.sv
module tx_fifo_chk #(
  parameter int unsigned CW    = 10,
  parameter int unsigned THR_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic             flush_busy_o,
  input logic             wr_ready_o,
  input logic             rd_valid_o,
  input logic             rd_ready_i,
  input logic             underflow_o,
  input logic             cfg_sf_i,
  input logic             cfg_csum_full_i,
  input logic             in_frame,
  input logic [CW-1:0]    frames,
  input logic [CW-1:0]    level,
  input logic [THR_W-1:0] start_lvl
);

  assert_sf_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !in_frame && (cfg_sf_i || cfg_csum_full_i)) |-> (frames != '0));

  assert_thr_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !in_frame && frames == '0) |-> (32'(level) >= 32'(start_lvl)));

  assert_no_empty_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (level != '0));

  assert_flush_starts_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> flush_busy_o);

  assert_flush_one_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_busy_o && !flush_i) |=> !flush_busy_o);

  assert_flush_empties_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_busy_o |=> (level == '0));

  assert_flush_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_busy_o |-> (!wr_ready_o && !rd_valid_o));

  assert_uf_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underflow_o) |-> $past(rd_ready_i && !rd_valid_o && in_frame));

  assert_uf_flush_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underflow_o) |-> flush_busy_o);

endmodule

bind tx_thresh_fifo tx_fifo_chk #(.CW(CW), .THR_W(tx_fifo_pkg::THR_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .flush_i         (flush_i),
  .flush_busy_o    (flush_busy_o),
  .wr_ready_o      (wr_ready_o),
  .rd_valid_o      (rd_valid_o),
  .rd_ready_i      (rd_ready_i),
  .underflow_o     (underflow_o),
  .cfg_sf_i        (cfg_sf_i),
  .cfg_csum_full_i (cfg_csum_full_i),
  .in_frame        (in_frame),
  .frames          (frames),
  .level           (level),
  .start_lvl       (start_lvl)
);

// File: tb/test_tx_thresh_fifo.sv
module test_tx_thresh_fifo;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0, wr_last = 1'b0, wr_ready;
  logic [7:0] wr_data = '0;
  logic       rd_valid, rd_last, rd_ready = 1'b0;
  logic [7:0] rd_data;
  logic       cfg_sf = 1'b0, cfg_csum = 1'b0, flush = 1'b0;
  logic [8:0] cfg_req = '0;
  logic       flush_busy, underflow;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  tx_thresh_fifo i_tx_thresh_fifo (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_last_i(wr_last), .wr_ready_o(wr_ready),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_last_o(rd_last), .rd_ready_i(rd_ready),
    .cfg_sf_i(cfg_sf), .cfg_csum_full_i(cfg_csum), .cfg_thr_req_i(cfg_req),
    .flush_i(flush), .flush_busy_o(flush_busy), .underflow_o(underflow)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_thr(input int r);
    if (r <= 32)  return 32;
    if (r <= 64)  return 64;
    if (r <= 128) return 128;
    if (r <= 192) return 192;
    return 256;
  endfunction

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(seed * 13 + i);
  endfunction

  // called and returns at a falling edge
  task automatic put(input logic [7:0] d, input bit l);
    chk(wr_ready == 1'b1, "R2 write accepted", int'(wr_ready), 1);
    wr_valid = 1'b1; wr_data = d; wr_last = l;
    @(posedge clk); #1;
    wr_valid = 1'b0; wr_last = 1'b0;
    @(negedge clk);
  endtask

  task automatic take(input logic [7:0] d, input bit l, input string req);
    chk(rd_valid == 1'b1, req, int'(rd_valid), 1);
    chk(rd_data == d, req, int'(rd_data), int'(d));
    chk(rd_last == l, req, int'(rd_last), int'(l));
    rd_ready = 1'b1;
    @(posedge clk); #1;
    rd_ready = 1'b0;
    @(negedge clk);
  endtask

  // frame with a check of the read side after each non-final byte
  task automatic put_frame_hold(input int seed, input int len, input int thr, input string req);
    for (int i = 0; i < len; i++) begin
      put(pat(seed, i), i == len - 1);
      if (i < len - 1) chk(rd_valid == (i + 1 >= thr), req, int'(rd_valid), int'(i + 1 >= thr));
      else             chk(rd_valid == 1'b1, req, int'(rd_valid), 1);
    end
  endtask

  task automatic drain(input int seed, input int len, input string req);
    for (int i = 0; i < len; i++) take(pat(seed, i), i == len - 1, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int reqs[15] = '{0, 1, 32, 33, 64, 65, 100, 128, 129, 150, 192, 193, 255, 300, 511};
    int lens[5]  = '{1, 2, 31, 40, 300};
    int seed;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(rd_valid == 1'b0,   "R1 rd_valid",   int'(rd_valid), 0);
    chk(wr_ready == 1'b1,   "R1 wr_ready",   int'(wr_ready), 1);
    chk(flush_busy == 1'b0, "R1 flush_busy", int'(flush_busy), 0);
    chk(underflow == 1'b0,  "R1 underflow",  int'(underflow), 0);

    // R5 threshold sweep, R11 continuation while draining, R2 order
    seed = 1;
    foreach (reqs[k]) begin
      cfg_sf = 1'b0; cfg_csum = 1'b0; cfg_req = 9'(reqs[k]);
      put_frame_hold(seed, 300, exp_thr(reqs[k]), "R5 threshold release");
      drain(seed, 300, "R2 R11 data after start");
      chk(rd_valid == 1'b0, "R2 empty after drain", int'(rd_valid), 0);
      seed++;
    end

    // R3 store-and-forward, R4 checksum forcing
    for (int m = 0; m < 2; m++) begin
      cfg_sf = (m == 0); cfg_csum = (m == 1); cfg_req = '0;
      foreach (lens[k]) begin
        put_frame_hold(seed, lens[k], 1000, (m == 0) ? "R3 held until last" : "R4 csum forces hold");
        drain(seed, lens[k], "R2 data");
        seed++;
      end
    end

    // R2 two stored frames in sequence
    cfg_sf = 1'b1; cfg_csum = 1'b0;
    put_frame_hold(seed, 3, 1000, "R3 first frame");
    for (int i = 0; i < 4; i++) put(pat(seed + 1, i), i == 3);
    drain(seed, 3, "R2 first frame");
    drain(seed + 1, 4, "R2 second frame");
    chk(rd_valid == 1'b0, "R2 empty", int'(rd_valid), 0);
    seed += 2;

    // R6 short frames under the top start level
    cfg_sf = 1'b0; cfg_req = 9'd511;
    foreach (lens[k]) begin
      if (lens[k] < 256) begin
        put_frame_hold(seed, lens[k], 256, "R6 short frame release");
        drain(seed, lens[k], "R6 data");
        seed++;
      end
    end

    // R9 underflow and R10 discard
    cfg_req = 9'd32;
    for (int i = 0; i < 32; i++) begin
      put(pat(seed, i), 1'b0);
      chk(rd_valid == (i + 1 >= 32), "R5 level 32", int'(rd_valid), int'(i + 1 >= 32));
    end
    for (int i = 0; i < 32; i++) take(pat(seed, i), 1'b0, "R11 continuation");
    chk(rd_valid == 1'b0, "R9 empty mid frame", int'(rd_valid), 0);
    chk(underflow == 1'b0, "R9 no underflow yet", int'(underflow), 0);
    rd_ready = 1'b1;
    @(posedge clk); #1;
    rd_ready = 1'b0;
    @(negedge clk);
    chk(underflow == 1'b1,  "R9 underflow set",  int'(underflow), 1);
    chk(flush_busy == 1'b1, "R9 auto flush",     int'(flush_busy), 1);
    chk(wr_ready == 1'b0,   "R8 write blocked",  int'(wr_ready), 0);
    chk(rd_valid == 1'b0,   "R8 read blocked",   int'(rd_valid), 0);
    @(negedge clk);
    chk(flush_busy == 1'b0, "R9 flush one cycle", int'(flush_busy), 0);
    for (int i = 32; i < 100; i++) begin
      put(pat(seed, i), i == 99);
      chk(rd_valid == 1'b0, "R10 tail discarded", int'(rd_valid), 0);
    end
    seed++;
    put_frame_hold(seed, 5, 32, "R10 next frame stored");
    drain(seed, 5, "R10 next frame data");
    chk(underflow == 1'b1, "R9 underflow sticky", int'(underflow), 1);
    seed++;

    // R7 and R8 host flush
    cfg_req = 9'd511;
    for (int i = 0; i < 20; i++) put(pat(seed, i), 1'b0);
    chk(rd_valid == 1'b0, "R5 partial held", int'(rd_valid), 0);
    flush = 1'b1;
    @(posedge clk); #1;
    flush = 1'b0;
    wr_valid = 1'b1; wr_data = 8'hEE; wr_last = 1'b1;
    @(negedge clk);
    chk(flush_busy == 1'b1, "R7 flush busy",     int'(flush_busy), 1);
    chk(wr_ready == 1'b0,   "R8 write blocked",  int'(wr_ready), 0);
    chk(rd_valid == 1'b0,   "R8 read blocked",   int'(rd_valid), 0);
    @(posedge clk); #1;
    wr_valid = 1'b0; wr_last = 1'b0;
    @(negedge clk);
    chk(flush_busy == 1'b0, "R7 flush cleared",   int'(flush_busy), 0);
    chk(underflow == 1'b0,  "R9 cleared by flush", int'(underflow), 0);
    chk(rd_valid == 1'b0,   "R8 offered write not stored", int'(rd_valid), 0);
    seed++;
    put_frame_hold(seed, 3, 256, "R7 frame after flush");
    drain(seed, 3, "R7 old bytes gone");
    chk(rd_valid == 1'b0, "R7 empty", int'(rd_valid), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule